// File: doc/BRIEF.md
# Serial-In Shift Register with Strobe-Controlled Storage Latch

The block turns a serial bit stream into a parallel word. Each rising clock edge moves the serial input one stage along an internal shift chain. Every stage of that chain feeds its own storage latch. While the strobe input is high, the latches pass the chain contents straight through. When strobe falls, the latches capture the chain contents and hold them. The parallel outputs are driven from the latches only while output enable is high. When output enable is low, the parallel outputs float.

Two serial outputs let several blocks be chained. The direct one is the last stage of the chain. The retimed one copies the last stage on the falling clock edge, so it lags the direct one by half a clock period. The retimed output gives a following block half a cycle of hold margin. An active-low asynchronous reset clears the chain, the latches and the retimed output. Reset is released in step with the clock.

Top module: `sipo_strobe_latch`

## Requirements
- R1: On every rising clock edge the chain shifts by one stage. The serial input enters stage 0, and stage i takes the old value of stage i-1.
- R2: The direct serial output always equals stage 7, the last stage of the chain.
- R3: The retimed serial output takes the value of stage 7 on each falling clock edge. Between a rising edge and the next falling edge it still shows the value of stage 7 from before that rising edge.
- R4: While strobe is high, latch bit i equals chain stage i and follows every shift.
- R5: From a falling edge of strobe, and for as long as strobe stays low, the latch keeps the chain value it had at that falling edge, whatever is shifted in afterwards.
- R6: While output enable is high, parallel output bit i drives latch bit i. While output enable is low, all parallel bits are high-impedance, so a pulled-up bus reads all ones.
- R7: Both serial outputs keep following the chain whatever the state of strobe and output enable.
- R8: While reset is low, the chain, the latch and the retimed serial output are all zero. Reset is applied at once and is released on a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High: latch transparent. Falling edge: capture |
| out_en | input | 1 | High: drive the parallel outputs |
| par_out | output | 8 | Three-state parallel outputs from the latch |
| ser_out | output | 1 | Last chain stage, for cascading |
| ser_out_late | output | 1 | Last stage retimed on the falling clock edge |

## Verification
The bench starts with directed patterns. It shifts a mixed byte in with strobe high and the outputs enabled, which shows bit order and transparency. It then drops strobe and shifts a complementary byte, which separates a latch that holds from one that keeps following. It toggles output enable over a held value that has zero bits, which separates a floating bus from a driven one. Random stretches then vary serial data, strobe and enable at the same time. Each cycle, the retimed output is sampled both before and after the falling clock edge, which confirms the half-period lag and separates it from the direct output.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned SIPO_WIDTH_DEFAULT = 8;
  localparam int unsigned SIPO_SYNC_DEFAULT  = 2;
endpackage

// File: rtl/sipo_rst_sync.sv
module sipo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages,
  output logic             last_fast,
  output logic             last_late
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_d;
  logic             late_q;
  logic             late_d;

  always_comb begin
    sr_d   = {sr_q[MSB-1:0], ser_in};
    late_d = sr_q[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) late_q <= 1'b0;
    else        late_q <= late_d;
  end

  assign stages    = sr_q;
  assign last_fast = sr_q[MSB];
  assign last_late = late_q;

  a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sr_q == {$past(sr_q[MSB-1:0]), $past(ser_in)}));

  a_r3_late_lags_half: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (late_q == sr_q[MSB]));
endmodule

// File: rtl/sipo_store_latch.sv
module sipo_store_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] hold_q;

  always_latch begin
    if (!rst_n)      hold_q = '0;
    else if (strobe) hold_q = din;
  end

  assign dout = hold_q;
endmodule

// File: rtl/sipo_strobe_latch.sv
module sipo_strobe_latch
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH       = SIPO_WIDTH_DEFAULT,
  parameter int unsigned SYNC_STAGES = SIPO_SYNC_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             strobe,
  input  logic             out_en,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out,
  output logic             ser_out_late
);
  logic             rst_n_s;
  logic [WIDTH-1:0] chain;
  logic [WIDTH-1:0] held;

  sipo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ser_in    (ser_in),
    .stages    (chain),
    .last_fast (ser_out),
    .last_late (ser_out_late)
  );

  sipo_store_latch #(.WIDTH(WIDTH)) u_latch (
    .rst_n  (rst_n_s),
    .strobe (strobe),
    .din    (chain),
    .dout   (held)
  );

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_drv
      assign par_out[gi] = out_en ? held[gi] : 1'bz;
    end
  endgenerate

  a_r4_follows_chain: assert property (@(posedge clk) disable iff (!rst_n_s)
    strobe |-> (held == chain));

  a_r5_holds_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!strobe && !$past(strobe) && $past(rst_n_s)) |-> $stable(held));
endmodule

// File: tb/test_sipo_strobe_latch.sv
`timescale 1ns/1ps
module test_sipo_strobe_latch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_in, strobe, out_en;
  wire  [7:0] par_out;
  wire        ser_out, ser_out_late;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] m_sr;
  logic [7:0] m_lat;
  logic       m_late;

  always #4 clk = ~clk;

  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (par_out[i]);
  end

  sipo_strobe_latch i_sipo_strobe_latch (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe),
    .out_en(out_en), .par_out(par_out), .ser_out(ser_out),
    .ser_out_late(ser_out_late)
  );

  function automatic logic [7:0] exp_par(input logic en, input logic [7:0] lat);
    return en ? lat : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic d, input logic s, input logic o);
    @(posedge clk);
    m_late = m_sr[7];
    m_sr   = {m_sr[6:0], ser_in};
    if (strobe) m_lat = m_sr;
    #1;
    chk("R1/R4/R6 par", par_out, exp_par(out_en, m_lat));
    chk("R2/R7 ser_out", {7'b0, ser_out}, {7'b0, m_sr[7]});
    chk("R3 late before fall", {7'b0, ser_out_late}, {7'b0, m_late});
    #1;
    ser_in = d; strobe = s; out_en = o;
    if (s) m_lat = m_sr;
    #1;
    chk("R5/R6 par after ctrl", par_out, exp_par(o, m_lat));
    @(negedge clk); #1;
    chk("R3 late after fall", {7'b0, ser_out_late}, {7'b0, m_sr[7]});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd2024;
    logic [7:0]  pat;
    void'($urandom(seed));
    rst_n = 1'b0; ser_in = 1'b1; strobe = 1'b1; out_en = 1'b1;
    m_sr = '0; m_lat = '0; m_late = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 par in reset", par_out, 8'h00);
    chk("R8 ser_out in reset", {7'b0, ser_out}, 8'h00);
    chk("R8 late in reset", {7'b0, ser_out_late}, 8'h00);
    ser_in = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // two synchronizer stages: the chain stays cleared for two more edges
    @(posedge clk); @(posedge clk); #2;
    chk("R8 still clear", par_out, 8'h00);

    // R1 R4: mixed byte shifted in with a transparent latch
    pat = 8'b1011_0011;
    for (int k = 7; k >= 0; k--) cyc(pat[k], 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R1 byte order", par_out, 8'b1011_0011);
    // R5: strobe falls, complement shifted, the latch holds the byte
    cyc(1'b1, 1'b0, 1'b1);
    pat = m_sr;
    for (int k = 0; k < 8; k++) cyc(~pat[k], 1'b0, 1'b1);
    chk("R5 held after shifting", par_out, m_lat);
    // R6: disable and re-enable over the held value
    cyc(1'b0, 1'b0, 1'b0);
    chk("R6 floating", par_out, 8'hFF);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R6 driven again", par_out, m_lat);
    // R7: serial outputs keep shifting with strobe low and outputs off
    for (int k = 0; k < 10; k++) cyc(k[0], 1'b0, 1'b0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic s_r, o_r;
      s_r = ($urandom % 8 == 0) ? ~strobe : strobe;
      o_r = ($urandom % 6 == 0) ? ~out_en : out_en;
      cyc(1'($urandom), s_r, o_r);
    end

    // R8: asynchronous reset mid-run
    @(posedge clk); #2; rst_n = 1'b0; out_en = 1'b1; #1;
    chk("R8 async clear par", par_out, 8'h00);
    chk("R8 async clear late", {7'b0, ser_out_late}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule